// File: doc/BRIEF.md
# Pipelined Floating-Point Multiplier Core

This block multiplies two floating-point numbers held in a generic, parameterized format. Each operand arrives already unpacked: a sign bit, an `EXP_W`-bit biased exponent (bias `2^(EXP_W-1)-1`) and an `MAN_W+1`-bit mantissa whose top bit is the explicit leading digit. The core returns the product in the same unpacked layout. The result is truncated, not rounded, and a separate rounding stage further down the datapath is expected to finish the job.

The datapath has three register stages. The first stage forms the result sign and adds the two exponents at a width that keeps the carry, then rebiases the sum. The second stage multiplies the full mantissas. The third stage inspects the top bit of the product. It uses that bit to choose which window of the product is kept and to correct the exponent, and it checks that the exponent fits in range. A start strobe enters with each operand pair, and a matching done strobe leaves with the result. An incoming exception flag travels alongside the data, and the core ORs it with any range error it finds itself. One operand pair can be accepted on every clock.

Top module: `fpm_mul_core`

## Requirements
- R1: A start pulse with valid operands produces `done_o` high for exactly one cycle, three clock edges after the edge that samples `start_i`. A new operand pair may be issued on every cycle, and each one returns its own result in order.
- R2: The result sign is the XOR of the two operand signs. This holds for zero operands too.
- R3: Let BIAS be `2^(EXP_W-1)-1`, and let the product of the two mantissas carry `2*MAN_W+2` bits. If the product's top bit is 1, the result exponent is `ea+eb-BIAS+1`. Otherwise it is `ea+eb-BIAS`.
- R4: If the product's top bit is 1, the result mantissa is product bits `[2*MAN_W+1:MAN_W+1]`. Otherwise it is bits `[2*MAN_W:MAN_W]`. The lower bits are dropped without rounding, and bit `MAN_W` of a nonzero result mantissa is always 1.
- R5: A computed exponent below 0 or above `2^EXP_W-1` sets `exc_o`. In that case the value of the exponent field is not specified.
- R6: `exc_i` is carried with its operand pair and appears on `exc_o` together with `done_o`, ORed with the core's own range error.
- R7: If either operand's mantissa bit `MAN_W` is 0, the operand is zero. The result then has exponent 0 and mantissa 0, and it raises no range error whatever the exponents are.
- R8: While `done_o` is low, the result ports hold their last values. Reset clears `done_o`, `exc_o` and every result field to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and releases synchronously |
| start_i | input | 1 | Operand pair is valid this cycle |
| exc_i | input | 1 | Exception flag arriving with the operands |
| a_sign_i | input | 1 | Sign of operand A |
| a_exp_i | input | EXP_W | Biased exponent of operand A |
| a_mant_i | input | MAN_W+1 | Mantissa of operand A, leading bit explicit |
| b_sign_i | input | 1 | Sign of operand B |
| b_exp_i | input | EXP_W | Biased exponent of operand B |
| b_mant_i | input | MAN_W+1 | Mantissa of operand B, leading bit explicit |
| done_o | output | 1 | Result is valid this cycle |
| exc_o | output | 1 | Exception flag travelling with the result |
| p_sign_o | output | 1 | Product sign |
| p_exp_o | output | EXP_W | Product biased exponent |
| p_mant_o | output | MAN_W+1 | Truncated product mantissa |

## Verification
The operand table is built from three kinds of mantissa pair. Pairs whose product stays below 2 pick the lower window and leave the exponent uncorrected. Pairs whose product reaches 2 or more pick the upper window and add one to the exponent. All-ones mantissas show that the dropped low bits are truncated, not rounded. The exponents are chosen to land exactly on 0 and on the largest code, and just past each, so the range flag is checked on both sides of each edge. Further vectors cover zero operands with exponents that would otherwise overflow, an incoming exception flag on both normal and zero data, back-to-back issue, and idle cycles that show the outputs hold.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  // Which half of the double-width mantissa product holds the leading one.
  typedef enum logic {
    PROD_BELOW_TWO = 1'b0,
    PROD_AT_TWO    = 1'b1
  } prod_range_e;

  // Constant subtracted from the exponent sum: one less than the bias.
  function automatic int unsigned rebias_const(input int unsigned exp_w);
    return (32'd1 << (exp_w - 1)) - 32'd2;
  endfunction

endpackage

// File: rtl/fpm_front.sv
module fpm_front #(
  parameter int unsigned EXP_W = 5,
  parameter int unsigned MAN_W = 6,
  localparam int unsigned MW   = MAN_W + 1,
  localparam int unsigned XW   = EXP_W + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic          exc_i,
  input  logic          a_sign_i,
  input  logic [EXP_W-1:0] a_exp_i,
  input  logic [MW-1:0] a_mant_i,
  input  logic          b_sign_i,
  input  logic [EXP_W-1:0] b_exp_i,
  input  logic [MW-1:0] b_mant_i,
  output logic          vld_o,
  output logic          exc_o,
  output logic          sign_o,
  output logic          zero_o,
  output logic [XW-1:0] exp_o,
  output logic [MW-1:0] ma_o,
  output logic [MW-1:0] mb_o
);
  import fpm_pkg::*;

  localparam logic [XW-1:0] REBIAS = XW'(rebias_const(EXP_W));

  logic [EXP_W:0]  exp_sum;
  logic [XW-1:0]   exp_rebiased;
  logic            sign_d;
  logic            zero_d;

  always_comb begin
    exp_sum      = {1'b0, a_exp_i} + {1'b0, b_exp_i};
    exp_rebiased = {1'b0, exp_sum} - REBIAS;
    sign_d       = a_sign_i ^ b_sign_i;
    zero_d       = ~(a_mant_i[MW-1] & b_mant_i[MW-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_o  <= 1'b0;
      sign_o <= 1'b0;
      zero_o <= 1'b0;
      exp_o  <= '0;
      ma_o   <= '0;
      mb_o   <= '0;
    end else if (vld_i) begin
      exc_o  <= exc_i;
      sign_o <= sign_d;
      zero_o <= zero_d;
      exp_o  <= exp_rebiased;
      ma_o   <= a_mant_i;
      mb_o   <= b_mant_i;
    end
  end

endmodule

// File: rtl/fpm_mant_mul.sv
module fpm_mant_mul #(
  parameter int unsigned EXP_W = 5,
  parameter int unsigned MAN_W = 6,
  localparam int unsigned MW   = MAN_W + 1,
  localparam int unsigned PW   = 2 * MW,
  localparam int unsigned XW   = EXP_W + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic          exc_i,
  input  logic          sign_i,
  input  logic          zero_i,
  input  logic [XW-1:0] exp_i,
  input  logic [MW-1:0] ma_i,
  input  logic [MW-1:0] mb_i,
  output logic          vld_o,
  output logic          exc_o,
  output logic          sign_o,
  output logic          zero_o,
  output logic [XW-1:0] exp_o,
  output logic [PW-1:0] prod_o
);

  logic [PW-1:0] prod_d;

  always_comb begin
    prod_d = PW'(ma_i) * PW'(mb_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_o  <= 1'b0;
      sign_o <= 1'b0;
      zero_o <= 1'b0;
      exp_o  <= '0;
      prod_o <= '0;
    end else if (vld_i) begin
      exc_o  <= exc_i;
      sign_o <= sign_i;
      zero_o <= zero_i;
      exp_o  <= exp_i;
      prod_o <= prod_d;
    end
  end

  // R4: two set leading digits give a product of at least 1.0
  a_r4_prod_floor : assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !zero_o) |-> (prod_o[PW-1] || prod_o[PW-2]));

endmodule

// File: rtl/fpm_norm_sel.sv
module fpm_norm_sel #(
  parameter int unsigned EXP_W = 5,
  parameter int unsigned MAN_W = 6,
  localparam int unsigned MW   = MAN_W + 1,
  localparam int unsigned PW   = 2 * MW,
  localparam int unsigned XW   = EXP_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic             exc_i,
  input  logic             sign_i,
  input  logic             zero_i,
  input  logic [XW-1:0]    exp_i,
  input  logic [PW-1:0]    prod_i,
  output logic             done_o,
  output logic             exc_o,
  output logic             sign_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [MW-1:0]    mant_o
);
  import fpm_pkg::*;

  prod_range_e      range_sel;
  logic [XW-1:0]    exp_fix;
  logic [MW-1:0]    mant_win;
  logic             range_err;
  logic [EXP_W-1:0] exp_d;
  logic [MW-1:0]    mant_d;
  logic             exc_d;

  always_comb begin
    range_sel = prod_range_e'(prod_i[PW-1]);
    if (range_sel == PROD_AT_TWO) begin
      exp_fix  = exp_i;
      mant_win = prod_i[PW-1 -: MW];
    end else begin
      exp_fix  = exp_i - XW'(1);
      mant_win = prod_i[PW-2 -: MW];
    end
    range_err = |exp_fix[XW-1:EXP_W];
    if (zero_i) begin
      exp_d  = '0;
      mant_d = '0;
      exc_d  = exc_i;
    end else begin
      exp_d  = exp_fix[EXP_W-1:0];
      mant_d = mant_win;
      exc_d  = exc_i | range_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
    end else begin
      done_o <= vld_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_o  <= 1'b0;
      sign_o <= 1'b0;
      exp_o  <= '0;
      mant_o <= '0;
    end else if (vld_i) begin
      exc_o  <= exc_d;
      sign_o <= sign_i;
      exp_o  <= exp_d;
      mant_o <= mant_d;
    end
  end

  // R4: a nonzero result leaves with its leading digit set
  a_r4_lead_digit : assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (mant_o != '0)) |-> mant_o[MW-1]);

  // R8: result ports hold while no result is being delivered
  a_r8_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(mant_o) && $stable(exp_o) && $stable(sign_o)));

  // R7: a zero operand never raises the range flag by itself
  a_r7_zero_quiet : assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && zero_i && !exc_i) |=> (!exc_o && mant_o == '0 && exp_o == '0));

endmodule

// File: rtl/fpm_mul_core.sv
module fpm_mul_core #(
  parameter int unsigned EXP_W = 5,
  parameter int unsigned MAN_W = 6,
  localparam int unsigned MW   = MAN_W + 1,
  localparam int unsigned PW   = 2 * MW,
  localparam int unsigned XW   = EXP_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             exc_i,
  input  logic             a_sign_i,
  input  logic [EXP_W-1:0] a_exp_i,
  input  logic [MW-1:0]    a_mant_i,
  input  logic             b_sign_i,
  input  logic [EXP_W-1:0] b_exp_i,
  input  logic [MW-1:0]    b_mant_i,
  output logic             done_o,
  output logic             exc_o,
  output logic             p_sign_o,
  output logic [EXP_W-1:0] p_exp_o,
  output logic [MW-1:0]    p_mant_o
);

  // Reset: asynchronous assertion, release aligned to the clock.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_core_n = rst_sync_q[1];

  logic          s1_vld, s1_exc, s1_sign, s1_zero;
  logic [XW-1:0] s1_exp;
  logic [MW-1:0] s1_ma, s1_mb;
  logic          s2_vld, s2_exc, s2_sign, s2_zero;
  logic [XW-1:0] s2_exp;
  logic [PW-1:0] s2_prod;

  fpm_front #(.EXP_W(EXP_W), .MAN_W(MAN_W)) front_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .vld_i    (start_i),
    .exc_i    (exc_i),
    .a_sign_i (a_sign_i),
    .a_exp_i  (a_exp_i),
    .a_mant_i (a_mant_i),
    .b_sign_i (b_sign_i),
    .b_exp_i  (b_exp_i),
    .b_mant_i (b_mant_i),
    .vld_o    (s1_vld),
    .exc_o    (s1_exc),
    .sign_o   (s1_sign),
    .zero_o   (s1_zero),
    .exp_o    (s1_exp),
    .ma_o     (s1_ma),
    .mb_o     (s1_mb)
  );

  fpm_mant_mul #(.EXP_W(EXP_W), .MAN_W(MAN_W)) mul_i (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .vld_i  (s1_vld),
    .exc_i  (s1_exc),
    .sign_i (s1_sign),
    .zero_i (s1_zero),
    .exp_i  (s1_exp),
    .ma_i   (s1_ma),
    .mb_i   (s1_mb),
    .vld_o  (s2_vld),
    .exc_o  (s2_exc),
    .sign_o (s2_sign),
    .zero_o (s2_zero),
    .exp_o  (s2_exp),
    .prod_o (s2_prod)
  );

  fpm_norm_sel #(.EXP_W(EXP_W), .MAN_W(MAN_W)) norm_i (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .vld_i  (s2_vld),
    .exc_i  (s2_exc),
    .sign_i (s2_sign),
    .zero_i (s2_zero),
    .exp_i  (s2_exp),
    .prod_i (s2_prod),
    .done_o (done_o),
    .exc_o  (exc_o),
    .sign_o (p_sign_o),
    .exp_o  (p_exp_o),
    .mant_o (p_mant_o)
  );

  // R1: every accepted pair is answered three edges later
  a_r1_latency : assert property (@(posedge clk) disable iff (!rst_core_n)
    start_i |-> ##3 done_o);

  // R2: product sign follows the operand signs
  a_r2_sign : assert property (@(posedge clk) disable iff (!rst_core_n)
    start_i |-> ##3 (p_sign_o == $past(a_sign_i ^ b_sign_i, 3)));

  // R6: an incoming exception is never lost
  a_r6_exc_carry : assert property (@(posedge clk) disable iff (!rst_core_n)
    (start_i && exc_i) |-> ##3 exc_o);

  // R7: a zero operand yields a zero result
  a_r7_zero : assert property (@(posedge clk) disable iff (!rst_core_n)
    (start_i && !(a_mant_i[MW-1] && b_mant_i[MW-1])) |-> ##3
      (p_mant_o == '0 && p_exp_o == '0 && exc_o == $past(exc_i, 3)));

endmodule

// File: tb/fpm_mul_core_tb_top.sv
module fpm_mul_core_tb_top;

  localparam int EW = 5;
  localparam int MW = 7;
  localparam int NV = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          exc_i = 1'b0;
  logic          a_sign_i = 1'b0;
  logic [EW-1:0] a_exp_i = '0;
  logic [MW-1:0] a_mant_i = '0;
  logic          b_sign_i = 1'b0;
  logic [EW-1:0] b_exp_i = '0;
  logic [MW-1:0] b_mant_i = '0;
  logic          done_o, exc_o, p_sign_o;
  logic [EW-1:0] p_exp_o;
  logic [MW-1:0] p_mant_o;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk = ~clk;

  fpm_mul_core #(.EXP_W(EW), .MAN_W(MW-1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .exc_i(exc_i),
    .a_sign_i(a_sign_i), .a_exp_i(a_exp_i), .a_mant_i(a_mant_i),
    .b_sign_i(b_sign_i), .b_exp_i(b_exp_i), .b_mant_i(b_mant_i),
    .done_o(done_o), .exc_o(exc_o), .p_sign_o(p_sign_o),
    .p_exp_o(p_exp_o), .p_mant_o(p_mant_o)
  );

  // {a_s,a_e,a_m, b_s,b_e,b_m, exc_in, exp_sign,exp_e,exp_m,exp_exc, check_exp}
  localparam logic [41:0] VEC [NV] = '{
    {1'b0,5'd15,7'h40, 1'b0,5'd15,7'h40, 1'b0, 1'b0,5'd15,7'h40,1'b0,1'b1},
    {1'b1,5'd16,7'h60, 1'b0,5'd14,7'h60, 1'b0, 1'b1,5'd16,7'h48,1'b0,1'b1},
    {1'b1,5'd20,7'h70, 1'b1,5'd3, 7'h50, 1'b0, 1'b0,5'd9, 7'h46,1'b0,1'b1},
    {1'b0,5'd10,7'h7F, 1'b0,5'd10,7'h7F, 1'b0, 1'b0,5'd6, 7'h7E,1'b0,1'b1},
    {1'b0,5'd1, 7'h41, 1'b0,5'd14,7'h41, 1'b0, 1'b0,5'd0, 7'h42,1'b0,1'b1},
    {1'b0,5'd1, 7'h40, 1'b0,5'd13,7'h40, 1'b0, 1'b0,5'd0, 7'h40,1'b1,1'b0},
    {1'b0,5'd31,7'h60, 1'b0,5'd14,7'h60, 1'b0, 1'b0,5'd31,7'h48,1'b0,1'b1},
    {1'b0,5'd31,7'h60, 1'b0,5'd15,7'h60, 1'b0, 1'b0,5'd0, 7'h48,1'b1,1'b0},
    {1'b0,5'd31,7'h00, 1'b1,5'd31,7'h50, 1'b0, 1'b1,5'd0, 7'h00,1'b0,1'b1},
    {1'b0,5'd15,7'h40, 1'b0,5'd15,7'h40, 1'b1, 1'b0,5'd15,7'h40,1'b1,1'b1},
    {1'b1,5'd20,7'h55, 1'b1,5'd2, 7'h3F, 1'b1, 1'b0,5'd0, 7'h00,1'b1,1'b1},
    {1'b0,5'd31,7'h40, 1'b0,5'd31,7'h40, 1'b0, 1'b0,5'd0, 7'h40,1'b1,1'b0}
  };

  task automatic check(input string req, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic [41:0] v);
    start_i  = 1'b1;
    a_sign_i = v[41]; a_exp_i = v[40:36]; a_mant_i = v[35:29];
    b_sign_i = v[28]; b_exp_i = v[27:23]; b_mant_i = v[22:16];
    exc_i    = v[15];
  endtask

  task automatic idle();
    start_i = 1'b0; exc_i = 1'b0;
  endtask

  task automatic check_result(input logic [41:0] v, input int idx);
    string tag;
    tag = $sformatf("vec%0d", idx);
    check("R1", {tag, " done"}, 16'(done_o), 16'd1);
    check("R2", {tag, " sign"}, 16'(p_sign_o), 16'(v[14]));
    check("R4", {tag, " mant"}, 16'(p_mant_o), 16'(v[8:2]));
    check("R5", {tag, " exc"}, 16'(exc_o), 16'(v[1]));
    if (v[0]) check("R3", {tag, " exp"}, 16'(p_exp_o), 16'(v[13:9]));
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    $display("FAIL R1 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8", "reset done", 16'(done_o), 16'd0);
    check("R8", "reset exc", 16'(exc_o), 16'd0);
    check("R8", "reset mant", 16'(p_mant_o), 16'd0);
    check("R8", "reset exp", 16'(p_exp_o), 16'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table: one vector at a time, R1 latency checked cycle by cycle
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk); idle();
      check("R1", "early done+1", 16'(done_o), 16'd0);
      @(negedge clk);
      check("R1", "early done+2", 16'(done_o), 16'd0);
      @(negedge clk);
      check_result(VEC[i], i);
      @(negedge clk);
      check("R1", "single pulse", 16'(done_o), 16'd0);
    end

    // R1: back-to-back issue, results in order every cycle
    drive(VEC[1]); @(negedge clk);
    drive(VEC[2]); @(negedge clk);
    drive(VEC[6]); @(negedge clk);
    idle();
    check_result(VEC[1], 101);
    @(negedge clk); check_result(VEC[2], 102);
    @(negedge clk); check_result(VEC[6], 106);

    // R8: outputs hold while idle
    repeat (5) @(negedge clk);
    check("R8", "hold done", 16'(done_o), 16'd0);
    check("R8", "hold mant", 16'(p_mant_o), 16'h48);
    check("R8", "hold exp", 16'(p_exp_o), 16'd31);

    // R8: mid-run reset clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R8", "reset again mant", 16'(p_mant_o), 16'd0);
    check("R8", "reset again exp", 16'(p_exp_o), 16'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7: zero operand after reset, exponents would overflow otherwise
    drive(VEC[8]);
    @(negedge clk); idle();
    repeat (2) @(negedge clk);
    check_result(VEC[8], 108);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule